// File: doc/BRIEF.md
# Parallel-Prefix Compound Adder

This block adds two unsigned W-bit operands and produces two sums at once: the plain sum a+b and the incremented sum a+b+1, each with its own carry out. Both come from one shared carry network. Every bit position is classed as kill, propagate or generate, and a Kogge-Stone prefix tree combines those classes across the word. The +1 sum does not use a second adder or an incrementer. Each prefix is composed once more with a generate placed below bit 0, which acts as a carry into the word.

A select input picks which of the two sums, with its carry, is driven to the result port. In a floating-point datapath this select is the rounding decision. Because both candidates already exist, no increment stage follows the decision. The block is purely combinational. It has no registers, no clock and no reset.

Top module: `pp_compound_adder`

## Requirements
- R1: `sum0` and `co0` together equal a+b, taken as a (W+1)-bit value with `co0` as the top bit.
- R2: `sum1` and `co1` together equal a+b+1, taken as a (W+1)-bit value with `co1` as the top bit.
- R3: When `sel` is 0, `result` and `res_co` equal a+b.
- R4: When `sel` is 1, `result` and `res_co` equal a+b+1.
- R5: All outputs are combinational functions of `a`, `b` and `sel`. A change on the inputs is visible on the outputs in the same cycle.
- R6: For a=4 and b=14 (bit 2 alone set in a, bits 3 to 1 set in b), `sum0` is 18 with `co0`=0 and `sum1` is 19 with `co1`=0.
- R7: When a is all ones and b is zero, `sum0` is all ones with `co0`=0, and `sum1` is all zeros with `co1`=1.
- R8: When a and b are both all ones, `sum0` is all ones except bit 0, which is 0, and `co0`=1. `sum1` is all ones and `co1`=1.
- R9: Complementary alternating operands (a has ones in its odd bits, b has ones in its even bits) give `sum0` all ones with `co0`=0, and `sum1` zero with `co1`=1.
- R10: Whenever `co0` is 1, `co1` is also 1. Bit 0 of `sum1` is always the inverse of bit 0 of `sum0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| sel | input | 1 | Selects a+b+1 for the result when 1, and a+b when 0 |
| sum0 | output | W | Low W bits of a+b |
| co0 | output | 1 | Carry out of a+b |
| sum1 | output | W | Low W bits of a+b+1 |
| co1 | output | 1 | Carry out of a+b+1 |
| result | output | W | The sum chosen by `sel` |
| res_co | output | 1 | Carry out of the chosen sum |

## Verification
Every result of this block is due in the same cycle as the operands and select that produce it, because no register lies between any input and any output. The bench changes `a`, `b` and `sel` only on the falling clock edge. It samples all six outputs one nanosecond later, well before the next rising edge, so each check sees the settled value of the stimulus just applied. Expected values come from (W+1)-bit integer addition in the bench.

// File: rtl/pp_compound_adder.sv
module pp_compound_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  output logic [W-1:0] sum0,
  output logic         co0,
  output logic [W-1:0] sum1,
  output logic         co1,
  output logic [W-1:0] result,
  output logic         res_co
);
  localparam int L = (W > 1) ? $clog2(W) : 1;

  // per-bit status as (gen, prop): kill=00, prop=01, gen=10
  logic [W-1:0] gen_l [0:L];
  logic [W-1:0] prp_l [0:L];
  logic [W:0]   c0, c1;

  assign gen_l[0] = a & b;
  assign prp_l[0] = a ^ b;

  for (genvar lv = 0; lv < L; lv++) begin : g_lvl
    localparam int D = 1 << lv;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_op
        assign gen_l[lv+1][i] = gen_l[lv][i] | (prp_l[lv][i] & gen_l[lv][i-D]);
        assign prp_l[lv+1][i] = prp_l[lv][i] & prp_l[lv][i-D];
      end else begin : g_pass
        assign gen_l[lv+1][i] = gen_l[lv][i];
        assign prp_l[lv+1][i] = prp_l[lv][i];
      end
    end
  end

  // +0: carry-in treated as kill; +1: prefix composed with a generate below bit 0
  assign c0 = {gen_l[L], 1'b0};
  assign c1 = {gen_l[L] | prp_l[L], 1'b1};

  assign sum0   = prp_l[0] ^ c0[W-1:0];
  assign co0    = c0[W];
  assign sum1   = prp_l[0] ^ c1[W-1:0];
  assign co1    = c1[W];
  assign result = sel ? sum1 : sum0;
  assign res_co = sel ? co1 : co0;

  always_comb begin
    a_r1_plain_sum: assert ({co0, sum0} == ({1'b0, a} + {1'b0, b}))
      else $error("R1 plain sum mismatch");
    a_r2_incr_sum: assert ({co1, sum1} == ({co0, sum0} + {{W{1'b0}}, 1'b1}))
      else $error("R2 incremented sum is not plain sum plus one");
    a_r4_result_sel: assert ({res_co, result} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, sel}))
      else $error("R3/R4 result does not follow sel");
    a_r10_carry_order: assert (!co0 || co1)
      else $error("R10 co0 set without co1");
    a_r10_lsb: assert (sum1[0] == ~sum0[0])
      else $error("R10 lsb of sums not complementary");
  end
endmodule

// File: tb/pp_compound_adder_tb.sv
module pp_compound_adder_tb;
  localparam int W = 32;
  localparam int NV = 8;
  localparam logic [W-1:0] VA [0:NV-1] = '{32'h0, 32'h1, 32'h4, 32'hFFFF_FFFF,
                                          32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'h8000_0000, 32'h1234_5678};
  localparam logic [W-1:0] VB [0:NV-1] = '{32'h0, 32'h1, 32'hE, 32'h0,
                                          32'hFFFF_FFFF, 32'h5555_5555, 32'h8000_0000, 32'h0FED_CBA9};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic sel = 1'b0;
  logic [W-1:0] sum0, sum1, result;
  logic co0, co1, res_co;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pp_compound_adder #(.W(W)) u_dut (
    .a(a), .b(b), .sel(sel), .sum0(sum0), .co0(co0), .sum1(sum1), .co1(co1),
    .result(result), .res_co(res_co)
  );

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h sel=%0b)", req, act, exp, a, b, sel);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic s);
    logic [W:0] e0, e1;
    @(negedge clk);
    a = x; b = y; sel = s;
    #1;
    e0 = {1'b0, x} + {1'b0, y};
    e1 = e0 + 1;
    chk("R1", {co0, sum0}, e0);
    chk("R2", {co1, sum1}, e1);
    chk(s ? "R4" : "R3", {res_co, result}, s ? e1 : e0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2345;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R5: outputs follow inputs with no register; zero inputs after start
    #1;
    chk("R5", {co0, sum0}, '0);
    chk("R5", {co1, sum1}, {{W{1'b0}}, 1'b1});
    for (int i = 0; i < NV; i++) begin
      apply(VA[i], VB[i], 1'b0);
      apply(VA[i], VB[i], 1'b1);
    end
    // R6: worked example
    apply(32'h4, 32'hE, 1'b0);
    chk("R6", {co0, sum0}, 33'd18);
    chk("R6", {co1, sum1}, 33'd19);
    // R7
    apply('1, '0, 1'b1);
    chk("R7", {co0, sum0}, {1'b0, {W{1'b1}}});
    chk("R7", {co1, sum1}, {1'b1, {W{1'b0}}});
    // R8
    apply('1, '1, 1'b0);
    chk("R8", {co0, sum0}, {1'b1, {(W-1){1'b1}}, 1'b0});
    chk("R8", {co1, sum1}, {1'b1, {W{1'b1}}});
    // R9
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    chk("R9", {co0, sum0}, {1'b0, {W{1'b1}}});
    chk("R9", {co1, sum1}, {1'b1, {W{1'b0}}});
    // R5: same-cycle response to a sel flip with operands held
    @(negedge clk); sel = 1'b0; #1;
    chk("R5", {res_co, result}, {1'b0, {W{1'b1}}});
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] x, y;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      y = lfsr * 32'h9E37_79B9;
      apply(x, y, lfsr[3]);
      checks++;
      if (co0 && !co1) begin
        fails++;
        $display("FAIL R10: actual co1=%0b expected 1 with co0=1", co1);
      end
      checks++;
      if (sum1[0] !== ~sum0[0]) begin
        fails++;
        $display("FAIL R10: actual lsb1=%0b expected %0b", sum1[0], ~sum0[0]);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule